// File: doc/BRIEF.md
# Absolute-Link Queue Insert Unit

This unit links one entry into a circular, doubly linked queue held in memory. Every link is a 32-bit absolute byte address. A node keeps its forward link in the word at its own address and its backward link in the word four bytes above it. The caller gives the address of the new entry and the address of the node it should follow. Passing the queue header as that node inserts at the head. Passing the current last node (the header's backward link) inserts at the tail.

A start strobe begins the operation. The unit first reads the predecessor's forward link to find the successor. It then touches every word it is going to write. It writes only after all of those accesses have completed without error, so a failed access leaves the queue untouched. When the links are written, the unit compares the new entry's forward link with its backward link and reports the result as four condition flags. An equal result means the queue was empty before the insert, so software can use an insert as a lock-acquire test.

The memory port uses a request/acknowledge handshake. An error response during the checking reads ends the operation with an error indication.

Top module: `qlink_insert`

## Requirements
- R1: After reset, done, err, mem_req and all four flags are low.
- R2: After start, the unit issues four reads (mem_we=0) in this order: pred, entry, entry+4, then succ+4, where succ is the data returned by the first read. No write is issued before the last of these reads completes.
- R3: On success, exactly four writes follow, in this order:
  - succ to address entry
  - pred to address entry+4
  - entry to address succ+4
  - entry to address pred
- R4: On success, flag_z is 1 exactly when succ equals pred, which means the queue was empty before the insert.
- R5: On success, flag_n is 1 exactly when succ is less than pred as two's-complement 32-bit values.
- R6: On success, flag_c is 1 exactly when succ is less than pred as unsigned values, and flag_v is always 0.
- R7: If mem_err answers any of the four reads, the operation ends with done=1 and err=1, all flags are 0, and no write is issued.
- R8: done is high for exactly one clock per accepted start, and the flags and err are valid in that cycle.
- R9: A start pulse that arrives while an operation is in progress is ignored. It causes no memory access and no extra done.
- R10: While mem_req is high and neither mem_ack nor mem_err is high, mem_req, mem_addr, mem_we and mem_wdata stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an insert when idle |
| entry_addr | input | 32 | Address of the entry to insert |
| pred_addr | input | 32 | Address of the node the entry will follow |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation aborted by an access error |
| flag_n | output | 1 | Signed less-than of the entry's links |
| flag_z | output | 1 | Links equal (queue was empty) |
| flag_v | output | 1 | Always 0 |
| flag_c | output | 1 | Unsigned less-than of the entry's links |

## Verification
The case that is hardest to reach from the ports is one where flag_n and flag_c disagree. That needs a successor address with bit 31 set sitting next to a predecessor with a low address. The stimulus builds a header at such a high address and links an entry behind it. The next insert after that entry then has a negative successor and a positive predecessor. An abort on the entry read is forced by giving an entry address that the memory model refuses. A second start is pulsed in the middle of an operation. Any access that follows either of these stimuli is then caught as an unexpected item in the scoreboard.

// File: rtl/qlink_insert.sv
module qlink_insert #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] entry_addr,
  input  logic [AW-1:0] pred_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          done,
  output logic          err,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c
);
  localparam logic [AW-1:0] BACK_OFS = AW'(AW / 8);

  logic          busy;
  logic [2:0]    step;
  logic [AW-1:0] ent_q, pred_q, succ_q;

  assign mem_req = busy;
  assign mem_we  = step[2];

  always_comb begin
    mem_addr  = pred_q;
    mem_wdata = '0;
    case (step)
      3'd0: mem_addr = pred_q;
      3'd1: mem_addr = ent_q;
      3'd2: mem_addr = ent_q + BACK_OFS;
      3'd3: mem_addr = succ_q + BACK_OFS;
      3'd4: begin mem_addr = ent_q;             mem_wdata = succ_q; end
      3'd5: begin mem_addr = ent_q + BACK_OFS;  mem_wdata = pred_q; end
      3'd6: begin mem_addr = succ_q + BACK_OFS; mem_wdata = ent_q;  end
      default: begin mem_addr = pred_q;         mem_wdata = ent_q;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      ent_q <= '0;
      pred_q <= '0;
      succ_q <= '0;
      done <= 1'b0;
      err <= 1'b0;
      {flag_n, flag_z, flag_v, flag_c} <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          step   <= '0;
          ent_q  <= entry_addr;
          pred_q <= pred_addr;
          err    <= 1'b0;
        end
      end else if (mem_err && !step[2]) begin
        busy <= 1'b0;
        done <= 1'b1;
        err  <= 1'b1;
        {flag_n, flag_z, flag_v, flag_c} <= '0;
      end else if (mem_ack || (mem_err && step[2])) begin
        if (step == 3'd0) succ_q <= mem_rdata;
        if (step == 3'd7) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          flag_z <= (succ_q == pred_q);
          flag_n <= ($signed(succ_q) < $signed(pred_q));
          flag_c <= (succ_q < pred_q);
          flag_v <= 1'b0;
        end
        step <= step + 3'd1;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done && !mem_req && !err);
  // R2
  no_write_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_err |=> !mem_req);
  // R4
  z_excludes_less_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_z |-> !flag_n && !flag_c);
  // R6
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !flag_v);
  // R7
  abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> !flag_n && !flag_z && !flag_c);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: tb/tb_qlink_insert.sv
module tb_qlink_insert;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] entry_addr = '0, pred_addr = '0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic done, err, flag_n, flag_z, flag_v, flag_c;

  always #2 clk = ~clk;

  qlink_insert dut (.*);

  logic [31:0] mem [256];
  int vectors = 0, miscompares = 0, dones = 0;
  logic [64:0] acc_q [$];
  logic [4:0]  res_q [$];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack && !mem_err) begin
      if (mem_addr[30]) mem_err <= 1'b1;
      else begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && (mem_ack || mem_err)) begin
      if (acc_q.size() == 0)
        check(0, "R9 unexpected access", {mem_we, mem_addr, mem_wdata}, '0);
      else begin
        logic [64:0] e;
        e = acc_q.pop_front();
        if (e[64])
          check({mem_we, mem_addr, mem_wdata} == e, "R3 write order", {mem_we, mem_addr, mem_wdata}, e);
        else
          check(!mem_we && mem_addr == e[63:32], "R2 read order", {mem_we, mem_addr, 32'h0}, e);
      end
    end
    if (rst_n && done) begin
      dones++;
      if (res_q.size() == 0) check(0, "R8 extra done", 65'(1), '0);
      else begin
        logic [4:0] r;
        r = res_q.pop_front();
        check({err, flag_n, flag_z, flag_v, flag_c} == r, "R4 R5 R6 R7 flags",
              65'({err, flag_n, flag_z, flag_v, flag_c}), 65'(r));
      end
      check(acc_q.size() == 0, "R7 accesses left at done", 65'(acc_q.size()), '0);
    end
  end

  task automatic run(input logic [31:0] e, input logic [31:0] p, input int bad_step, input bit poke);
    logic [31:0] s;
    s = mem[p[9:2]];
    acc_q.push_back({1'b0, p, 32'h0});
    if (bad_step != 1) begin
      acc_q.push_back({1'b0, e, 32'h0});
      acc_q.push_back({1'b0, e + 32'd4, 32'h0});
      acc_q.push_back({1'b0, s + 32'd4, 32'h0});
      acc_q.push_back({1'b1, e, s});
      acc_q.push_back({1'b1, e + 32'd4, p});
      acc_q.push_back({1'b1, s + 32'd4, e});
      acc_q.push_back({1'b1, p, e});
      res_q.push_back({1'b0, $signed(s) < $signed(p), s == p, 1'b0, s < p});
    end else begin
      acc_q.push_back({1'b0, e, 32'h0});
      res_q.push_back(5'b10000);
    end
    @(posedge clk); #1;
    entry_addr = e; pred_addr = p; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 entry_addr = 32'h0000_0300; pred_addr = 32'h0000_0100; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (!done) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h40] = 32'h100; mem[8'h41] = 32'h100;
    mem[8'h10] = 32'h8000_0040; mem[8'h11] = 32'h8000_0040;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check({done, err, mem_req, flag_n, flag_z, flag_v, flag_c} == 0, "R1 reset",
          65'({done, err, mem_req, flag_n, flag_z, flag_v, flag_c}), '0);
    rst_n = 1'b1;
    run(32'h200, 32'h100, 0, 0);          // R4 empty queue
    run(32'h300, 32'h100, 0, 1);          // R3 head insert; R9 start while busy
    run(32'h400, mem[8'h41], 0, 0);       // R5 R6 tail insert, succ < pred
    run(32'h80, 32'h8000_0040, 0, 0);     // high header, empty
    run(32'hC0, 32'h80, 0, 0);            // R5 negative succ: N=1, C=0
    run(32'h4000_0100, 32'h100, 1, 0);    // R7 abort on entry read
    check(mem[8'h40] == 32'h300, "R7 queue unchanged", 65'(mem[8'h40]), 65'(32'h300));
    check(mem[8'h30] == 32'h8000_0040 && mem[8'h31] == 32'h80, "R3 links of entry",
          65'({mem[8'h30], mem[8'h31]}), 65'({32'h8000_0040, 32'h80}));
    check(dones == 6, "R8 R9 done count", 65'(dones), 65'(6));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule